// File: doc/BRIEF.md
# Synchronous Flow-Through Burst SRAM

This block is a single-clock static RAM with 32-bit words split into four byte lanes and an internal burst address generator. Every address, data and control input is sampled on the rising clock edge. Read data is not re-registered: once an edge has registered a read beat, the addressed word is driven combinationally for the rest of that cycle. A write command is held in registers and committed to the array at the following edge.

A burst opens when either of two start strobes is high. The processor-side strobe always begins with a read. The controller-side strobe lets that first beat be a write. The start address is loaded as the burst base. Later beats come from a 2-bit counter that steps only when the advance input is high. The counting order is linear or interleaved, picked by an order input sampled at the start. Three chip enables gate selection. A start while any of them is low deselects the block for the next cycle, which blanks the output and blocks writes.

Top module: `sfb_sram`

## Requirements
- R1: During and right after reset the block is deselected: `rvalid_o` is 0 and `rdata_o` is 0.
- R2: A cycle with `start_p_i` or `start_c_i` high and all of `ce_a_i`, `ce_b_i`, `ce_c_i` high loads `addr_i` as the burst base and beat 0. In the cycle after that edge, a read beat drives the word at that address on `rdata_o`, with `rvalid_o` high.
- R3: A start cycle with any chip enable low deselects the block from the next edge on. `rvalid_o` and `rdata_o` are then 0, and the array is not written even if write controls are high.
- R4: With `order_i` = 0 at the start, beat n addresses the base with its low two bits replaced by (base[1:0] + n) mod 4. The upper bits stay fixed.
- R5: With `order_i` = 1 at the start, beat n addresses the base with its low two bits replaced by base[1:0] XOR n.
- R6: In a selected burst the beat counter steps by one only in cycles with `adv_i` high. Otherwise it holds. After beat 3 it wraps to beat 0 in the same 4-word block.
- R7: Byte lane k (bits 8k+7..8k) is written only when `bwe_i` is 1 and `bw_i[k]` is 1. With `bwe_i` = 0 and `gw_i` = 0 nothing is written.
- R8: With `gw_i` = 1 all four lanes are written, whatever `bwe_i` and `bw_i` hold.
- R9: In a cycle where `start_p_i` is high, the write controls are ignored. The beat is a read and the array keeps its contents.
- R10: A write command applies to the beat address set up by the same edge. In the cycle after that edge, `rvalid_o` is 0 and `rdata_o` is 0. The data is stored at the next edge and is returned by later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Burst start address |
| start_p_i | input | 1 | Start strobe, read-only first beat |
| start_c_i | input | 1 | Start strobe, first beat may write |
| adv_i | input | 1 | Step the burst counter |
| ce_a_i | input | 1 | Chip enable A, active high |
| ce_b_i | input | 1 | Chip enable B, active high |
| ce_c_i | input | 1 | Chip enable C, active high |
| gw_i | input | 1 | Write all four lanes |
| bwe_i | input | 1 | Byte-write enable |
| bw_i | input | 4 | Per-lane byte-write selects |
| wdata_i | input | 32 | Write data |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| rdata_o | output | 32 | Flow-through read data, 0 when not valid |
| rvalid_o | output | 1 | High on a selected read beat |

## Verification
The bench builds the block with ADDR_W = 4, which gives 16 words in four burst blocks. That size makes it possible to run a full burst, including the wrap beat, from every start address in both orders and through both strobes. It also reaches all 16 byte-lane masks, all seven chip-enable patterns that leave at least one enable low, and a write burst that advances through a block. Expected words come from a 16-entry array in the bench, updated by lane masking and with beat addresses worked out by addition or XOR on the low two bits.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;
    localparam int BEAT_W = 2;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;
endpackage

// File: rtl/sfb_beat_gen.sv
module sfb_beat_gen
    import sfb_pkg::*;
(
    input  logic [BEAT_W-1:0] start_lo,
    input  logic [BEAT_W-1:0] beat,
    input  order_e            ord,
    output logic [BEAT_W-1:0] offset
);
    always_comb begin
        if (ord == ORD_INTERLEAVE) begin
            offset = start_lo ^ beat;
        end else begin
            offset = start_lo + beat;
        end
    end
endmodule

// File: rtl/sfb_lane_dec.sv
module sfb_lane_dec
    import sfb_pkg::*;
(
    input  logic             gw,
    input  logic             bwe,
    input  logic [LANES-1:0] bw,
    output logic [LANES-1:0] mask
);
    always_comb begin
        if (gw) begin
            mask = '1;
        end else if (bwe) begin
            mask = bw;
        end else begin
            mask = '0;
        end
    end
endmodule

// File: rtl/sfb_array.sv
module sfb_array
    import sfb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g]) begin
                store[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = store[addr];
    end
endmodule

// File: rtl/sfb_sram.sv
module sfb_sram
    import sfb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              start_p_i,
    input  logic              start_c_i,
    input  logic              adv_i,
    input  logic              ce_a_i,
    input  logic              ce_b_i,
    input  logic              ce_c_i,
    input  logic              gw_i,
    input  logic              bwe_i,
    input  logic [LANES-1:0]  bw_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              order_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              rvalid_o
);
    localparam int HI_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic              sel;
        logic [ADDR_W-1:0] base;
        logic [BEAT_W-1:0] cnt;
        order_e            ord;
        logic              wr;
        logic [LANES-1:0]  lanes;
        logic [WORD_W-1:0] wdata;
    } state_t;

    state_t            state_d, state_q;
    logic [LANES-1:0]  lane_mask;
    logic [BEAT_W-1:0] beat_off;
    logic [ADDR_W-1:0] beat_addr;
    logic [WORD_W-1:0] arr_rdata;
    logic [LANES-1:0]  arr_we;
    logic              start_any;
    logic              ce_all;
    logic              write_ok;

    sfb_lane_dec u_lane_dec (
        .gw   (gw_i),
        .bwe  (bwe_i),
        .bw   (bw_i),
        .mask (lane_mask)
    );

    sfb_beat_gen u_beat_gen (
        .start_lo (state_q.base[BEAT_W-1:0]),
        .beat     (state_q.cnt),
        .ord      (state_q.ord),
        .offset   (beat_off)
    );

    assign beat_addr = {state_q.base[ADDR_W-1 -: HI_W], beat_off};
    assign arr_we    = state_q.wr ? state_q.lanes : '0;

    sfb_array #(.ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .addr  (beat_addr),
        .we    (arr_we),
        .wdata (state_q.wdata),
        .rdata (arr_rdata)
    );

    always_comb begin
        state_d   = state_q;
        start_any = start_p_i | start_c_i;
        ce_all    = ce_a_i & ce_b_i & ce_c_i;

        if (start_any) begin
            state_d.sel  = ce_all;
            state_d.base = addr_i;
            state_d.cnt  = '0;
            state_d.ord  = order_e'(order_i);
        end else if (state_q.sel && adv_i) begin
            state_d.cnt = state_q.cnt + 1'b1;
        end

        write_ok      = state_d.sel && !start_p_i;
        state_d.wr    = write_ok && (|lane_mask);
        state_d.lanes = write_ok ? lane_mask : '0;
        state_d.wdata = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rvalid_o = state_q.sel && !state_q.wr;
    assign rdata_o  = rvalid_o ? arr_rdata : '0;
endmodule

// File: rtl/sfb_sram_chk.sv
module sfb_sram_chk
    import sfb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start_p_i,
    input logic              start_c_i,
    input logic              adv_i,
    input logic              ce_a_i,
    input logic              ce_b_i,
    input logic              ce_c_i,
    input logic              gw_i,
    input logic              bwe_i,
    input logic [LANES-1:0]  bw_i,
    input logic [WORD_W-1:0] rdata_o,
    input logic              rvalid_o
);
    // R1
    blank_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid_o |-> rdata_o == '0);

    // R3
    deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_p_i || start_c_i) && !(ce_a_i && ce_b_i && ce_c_i)
        |=> !rvalid_o && rdata_o == '0);

    // R9
    proc_start_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_p_i && ce_a_i && ce_b_i && ce_c_i |=> rvalid_o);

    // R10
    write_beat_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_c_i && !start_p_i && gw_i && ce_a_i && ce_b_i && ce_c_i
        |=> !rvalid_o);

    // R6
    hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o && !start_p_i && !start_c_i && !adv_i && !gw_i
        && !(bwe_i && (|bw_i))
        |=> rvalid_o && $stable(rdata_o));
endmodule

bind sfb_sram sfb_sram_chk u_sfb_sram_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_p_i (start_p_i),
    .start_c_i (start_c_i),
    .adv_i     (adv_i),
    .ce_a_i    (ce_a_i),
    .ce_b_i    (ce_b_i),
    .ce_c_i    (ce_c_i),
    .gw_i      (gw_i),
    .bwe_i     (bwe_i),
    .bw_i      (bw_i),
    .rdata_o   (rdata_o),
    .rvalid_o  (rvalid_o)
);

// File: tb/sfb_sram_bench.sv
module sfb_sram_bench;
    localparam int AW = 4;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          start_p, start_c, adv, ce_a, ce_b, ce_c, gw, bwe, order;
    logic [3:0]    bw;
    logic [31:0]   wdata;
    logic [31:0]   rdata;
    logic          rvalid;

    int total = 0;
    int bad   = 0;
    logic [31:0] ref_mem [N];

    always #5 clk = ~clk;

    sfb_sram #(.ADDR_W(AW)) u_sfb_sram (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (addr),
        .start_p_i (start_p),
        .start_c_i (start_c),
        .adv_i     (adv),
        .ce_a_i    (ce_a),
        .ce_b_i    (ce_b),
        .ce_c_i    (ce_c),
        .gw_i      (gw),
        .bwe_i     (bwe),
        .bw_i      (bw),
        .wdata_i   (wdata),
        .order_i   (order),
        .rdata_o   (rdata),
        .rvalid_o  (rvalid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        start_p = 0; start_c = 0; adv = 0; gw = 0; bwe = 0; bw = '0;
        ce_a = 1; ce_b = 1; ce_c = 1;
    endtask

    function automatic logic [AW-1:0] beat(input logic [AW-1:0] b, input int n,
                                           input logic ord);
        logic [1:0] o;
        o = ord ? (b[1:0] ^ 2'(n)) : (b[1:0] + 2'(n));
        return {b[AW-1:2], o};
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] m);
        logic [31:0] r;
        for (int k = 0; k < 4; k++)
            r[k*8 +: 8] = m[k] ? nw[k*8 +: 8] : old[k*8 +: 8];
        return r;
    endfunction

    // single write through the controller-side strobe
    task automatic wr1(input logic [AW-1:0] a, input logic [31:0] d, input logic g,
                       input logic be, input logic [3:0] m, input string tag);
        logic [3:0] eff;
        eff = g ? 4'hF : (be ? m : 4'h0);
        start_c = 1; addr = a; gw = g; bwe = be; bw = m; wdata = d;
        step();
        idle();
        chk({tag, " rvalid"}, {31'd0, rvalid}, {31'd0, (eff == 0)});
        step();
        ref_mem[a] = merge(ref_mem[a], d, eff);
    endtask

    task automatic rd1(input logic [AW-1:0] a, input string tag);
        start_p = 1; addr = a;
        step();
        idle();
        chk({tag, " valid"}, {31'd0, rvalid}, 32'd1);
        chk(tag, rdata, ref_mem[a]);
    endtask

    task automatic burst(input logic [AW-1:0] a, input logic ord, input logic use_p);
        start_p = use_p; start_c = !use_p; addr = a; order = ord;
        step();
        idle();
        chk(ord ? "R5 R2 beat0" : "R4 R2 beat0", rdata, ref_mem[a]);
        for (int n = 1; n <= 4; n++) begin
            adv = 1;
            step();
            chk(ord ? "R5 R6 beat" : "R4 R6 beat", rdata, ref_mem[beat(a, n, ord)]);
        end
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 0; addr = '0; wdata = '0; order = 0;
        idle();
        repeat (3) @(posedge clk);
        #1;
        chk("R1 rvalid", {31'd0, rvalid}, 32'd0);
        chk("R1 rdata", rdata, 32'd0);
        rst_n = 1;
        step();
        chk("R1 after release", {31'd0, rvalid}, 32'd0);

        for (int a = 0; a < N; a++) begin
            ref_mem[a] = '0;
            wr1(AW'(a), 32'hA5000000 + 32'(a) * 32'h00010203, 1, 0, 0, "R8 fill");
        end

        for (int o = 0; o < 2; o++)
            for (int p = 0; p < 2; p++)
                for (int a = 0; a < N; a++)
                    burst(AW'(a), o[0], p[0]);

        // R6 hold without advance
        start_c = 1; addr = 4'd6; order = 0;
        step();
        idle();
        repeat (2) begin
            step();
            chk("R6 hold", rdata, ref_mem[6]);
        end
        adv = 1;
        step();
        idle();
        chk("R6 step after hold", rdata, ref_mem[7]);

        // R7 every lane mask
        for (int m = 0; m < 16; m++) begin
            wr1(4'd3, 32'h11223344 ^ (32'(m) * 32'h01010101), 0, 1, 4'(m), "R7 mask");
            rd1(4'd3, "R7 readback");
        end
        wr1(4'd4, 32'hDEADBEEF, 0, 0, 4'hF, "R7 no bwe");
        rd1(4'd4, "R7 no bwe readback");

        // R8 global write over disabled byte controls
        wr1(4'd5, 32'hCAFEF00D, 1, 0, 4'h0, "R8 gw");
        rd1(4'd5, "R8 gw readback");

        // R9 write controls ignored on processor strobe
        start_p = 1; addr = 4'd8; gw = 1; bwe = 1; bw = 4'hF; wdata = 32'h0BADC0DE;
        step();
        idle();
        chk("R9 read beat", {31'd0, rvalid}, 32'd1);
        chk("R9 old data", rdata, ref_mem[8]);
        step();
        rd1(4'd8, "R9 unchanged");

        // R3 each enable pattern with a lane low
        for (int c = 0; c < 7; c++) begin
            start_c = 1; addr = 4'd10; gw = 1; wdata = 32'h5EAF00D0 + 32'(c);
            ce_a = c[0]; ce_b = c[1]; ce_c = c[2];
            step();
            idle();
            chk("R3 rvalid", {31'd0, rvalid}, 32'd0);
            chk("R3 rdata", rdata, 32'd0);
            step();
            rd1(4'd10, "R3 no write");
        end

        // R10 write burst, interleaved from 9
        start_c = 1; addr = 4'd9; order = 1; gw = 1; wdata = 32'h90000000;
        step();
        chk("R10 blank", {31'd0, rvalid}, 32'd0);
        ref_mem[9] = 32'h90000000;
        for (int n = 1; n < 4; n++) begin
            start_c = 0; adv = 1; gw = 1; wdata = 32'h90000000 + 32'(n);
            step();
            chk("R10 blank", {31'd0, rvalid}, 32'd0);
            ref_mem[beat(4'd9, n, 1)] = wdata;
        end
        idle();
        step();
        burst(4'd9, 1, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule